// File: doc/BRIEF.md
# Aliasing Memory Region Decoder

This block sits between a processor core and its memories. Every cycle it looks at the 16-bit address and the read/write direction of the current access and says where that access belongs: an internal ROM shadow, an internal RAM shadow, or the external bus. For internal hits it also produces the offset into the shadow store. The offset is computed so that several address windows can land on the same storage. This models boards with incomplete address decoding, where for example a 256-byte window at $1000 repeats the bottom of RAM.

The layout is held in a small table of programmable map entries, loaded through a register write port. Each entry is an inclusive address range with a class, a fold mask, an offset base and a write-through flag. Entries are searched by index, and the lowest matching index wins. A write-through entry is meant for a small battery-backed area: the shadow copy is updated and the same write is also driven onto the external bus. Three active-low indicators, one for ROM, one for RAM and one for the bus, are driven from registers. Each stays lit for a programmable number of clocks, so that a single access remains visible.

Top module: `mem_region_decoder`

## Requirements
- R1: `acc_cls` encodes the class as 0 = unmapped, 1 = ROM, 2 = RAM. A valid access that matches no entry raises `ext_req`. `ext_wr` is high only when `ext_req` is high and the access is a write (`acc_rd` = 0).
- R2: An entry matches when its class field is ROM or RAM and `lo <= addr <= hi`. When several entries match, the one with the lowest index decides the class and the offset.
- R3: The shadow offset of a matching entry is `(base + ((addr - lo) & fold))` modulo 2^16. For unmapped addresses the offset is 0.
- R4: A ROM entry never matches an address below `ROM_FLOOR` (default $4000). Such an address falls through to the next matching entry, or to unmapped.
- R5: A write that decodes to ROM is discarded: `shadow_wr` and `ext_req` both stay low.
- R6: A valid write that decodes to RAM raises `shadow_wr`. A valid read of RAM or ROM leaves `ext_req` low.
- R7: A write to a RAM entry whose write-through flag is set raises `shadow_wr`, `ext_req` and `ext_wr` together. A read of the same entry stays internal.
- R8: After a clock edge with a valid ROM access, a valid RAM access or a raised `ext_req`, the matching indicator (`led_rom_n`, `led_ram_n`, `led_bus_n`) is low for exactly N cycles and then goes high. N is the stretch setting, with 0 treated as 1. A new trigger reloads the count.
- R9: After reset every entry is disabled, so all addresses are unmapped. The stretch setting is `STRETCH_RST`, and all indicators are high.
- R10: A configuration write (`cfg_we` = 1) to entry `cfg_idx` sets one field, chosen by `cfg_sel`: 0 = lo, 1 = hi, 2 = fold, 3 = base, 4 = control (`cfg_data[1:0]` class, `cfg_data[2]` write-through). `cfg_sel` = 7 sets the stretch from the low bits of `cfg_data`, and `cfg_idx` is then ignored. The values 5 and 6 change nothing.
- R11: While `acc_valid` is low, `shadow_wr` and `ext_req` are low and no indicator is triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Map entry index |
| cfg_sel | input | 3 | Field select |
| cfg_data | input | 16 | Field value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 16 | Access address |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_cls | output | 2 | Decoded class |
| shadow_ofs | output | 16 | Offset into the shadow store |
| shadow_wr | output | 1 | Write the shadow store |
| ext_req | output | 1 | Drive an external bus cycle |
| ext_wr | output | 1 | External cycle is a write |
| led_rom_n | output | 1 | ROM activity indicator, active low |
| led_ram_n | output | 1 | RAM activity indicator, active low |
| led_bus_n | output | 1 | Bus activity indicator, active low |

## Verification
The bench builds the decoder with NUM_ENTRIES = 4 and STRETCH_W = 3, so every entry index can be programmed and exercised in one short run. With these values the largest stretch of 7 and the zero-treated-as-one stretch are both reached within a few cycles. The four entries are enough for a mirror window that overlaps a larger RAM range, a ROM range that starts below the floor, and a write-through window. Together these cover priority, folding, floor fall-through and write-through against one reference layout.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int AW = 16;
  localparam int SELW = 3;

  localparam logic [1:0] CLS_BUS = 2'd0;
  localparam logic [1:0] CLS_ROM = 2'd1;
  localparam logic [1:0] CLS_RAM = 2'd2;

  localparam logic [SELW-1:0] SEL_LO      = 3'd0;
  localparam logic [SELW-1:0] SEL_HI      = 3'd1;
  localparam logic [SELW-1:0] SEL_FOLD    = 3'd2;
  localparam logic [SELW-1:0] SEL_BASE    = 3'd3;
  localparam logic [SELW-1:0] SEL_CTRL    = 3'd4;
  localparam logic [SELW-1:0] SEL_STRETCH = 3'd7;

  typedef struct packed {
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic [AW-1:0] fold;
    logic [AW-1:0] base;
    logic          wt;
    logic [1:0]    cls;
  } mrd_entry_t;

  function automatic logic entry_enabled(input mrd_entry_t e);
    return (e.cls == CLS_ROM) || (e.cls == CLS_RAM);
  endfunction

  function automatic logic entry_hit(input logic [AW-1:0] addr, input mrd_entry_t e,
                                     input logic [AW-1:0] floor_addr);
    logic in_rng;
    in_rng = (addr >= e.lo) && (addr <= e.hi);
    return entry_enabled(e) && in_rng && !((e.cls == CLS_ROM) && (addr < floor_addr));
  endfunction

  function automatic logic [AW-1:0] entry_ofs(input logic [AW-1:0] addr, input mrd_entry_t e);
    logic [AW-1:0] rel;
    rel = addr - e.lo;
    return e.base + (rel & e.fold);
  endfunction
endpackage

// File: rtl/mrd_cfg_regs.sv
module mrd_cfg_regs
  import mrd_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int STRETCH_W   = 8,
  parameter int STRETCH_RST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [SELW-1:0]      cfg_sel,
  input  logic [AW-1:0]        cfg_data,
  output mrd_entry_t           entries [NUM_ENTRIES],
  output logic [STRETCH_W-1:0] stretch
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic sel_me;
    assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries[g] <= '0;
      end else if (sel_me) begin
        case (cfg_sel)
          SEL_LO:   entries[g].lo   <= cfg_data;
          SEL_HI:   entries[g].hi   <= cfg_data;
          SEL_FOLD: entries[g].fold <= cfg_data;
          SEL_BASE: entries[g].base <= cfg_data;
          SEL_CTRL: begin
            entries[g].cls <= cfg_data[1:0];
            entries[g].wt  <= cfg_data[2];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stretch <= STRETCH_W'(STRETCH_RST);
    else if (cfg_we && cfg_sel == SEL_STRETCH) stretch <= cfg_data[STRETCH_W-1:0];
  end
endmodule

// File: rtl/mrd_match.sv
module mrd_match
  import mrd_pkg::*;
#(
  parameter int          NUM_ENTRIES = 8,
  parameter logic [15:0] ROM_FLOOR   = 16'h4000
) (
  input  logic [AW-1:0]          addr,
  input  mrd_entry_t             entries [NUM_ENTRIES],
  output logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [1:0]             cls,
  output logic                   wt,
  output logic [AW-1:0]          ofs
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = entry_hit(addr, entries[g], ROM_FLOOR);
  end

  // Scan from the top so the lowest matching index is applied last.
  always_comb begin
    cls = CLS_BUS;
    wt  = 1'b0;
    ofs = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        cls = entries[i].cls;
        wt  = entries[i].wt;
        ofs = entry_ofs(addr, entries[i]);
      end
    end
  end
endmodule

// File: rtl/mrd_led_stretch.sv
module mrd_led_stretch #(
  parameter int NUM_CH    = 3,
  parameter int STRETCH_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    trig,
  input  logic [STRETCH_W-1:0] stretch,
  output logic [NUM_CH-1:0]    led_n
);
  logic [STRETCH_W-1:0] load_val;
  assign load_val = (stretch == '0) ? STRETCH_W'(1) : stretch;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [STRETCH_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (trig[g])     cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign led_n[g] = (cnt == '0);
  end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int          NUM_ENTRIES = 8,
  parameter int          STRETCH_W   = 8,
  parameter int          STRETCH_RST = 4,
  parameter logic [15:0] ROM_FLOOR   = 16'h4000,
  localparam int         IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [2:0]       cfg_sel,
  input  logic [15:0]      cfg_data,
  input  logic             acc_valid,
  input  logic [15:0]      acc_addr,
  input  logic             acc_rd,
  output logic [1:0]       acc_cls,
  output logic [15:0]      shadow_ofs,
  output logic             shadow_wr,
  output logic             ext_req,
  output logic             ext_wr,
  output logic             led_rom_n,
  output logic             led_ram_n,
  output logic             led_bus_n
);
  mrd_entry_t           entries [NUM_ENTRIES];
  logic [STRETCH_W-1:0] stretch;
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic                 hit_wt;

  // Named events for the checker
  logic is_rom, is_ram, is_bus;
  logic rom_wr_drop;
  logic wt_wr;
  logic [2:0] led_trig;
  logic [2:0] led_vec;

  mrd_cfg_regs #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W),
    .STRETCH_W(STRETCH_W), .STRETCH_RST(STRETCH_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .entries(entries), .stretch(stretch)
  );

  mrd_match #(.NUM_ENTRIES(NUM_ENTRIES), .ROM_FLOOR(ROM_FLOOR)) u_match (
    .addr(acc_addr), .entries(entries), .hit_vec(hit_vec),
    .cls(acc_cls), .wt(hit_wt), .ofs(shadow_ofs)
  );

  assign is_rom      = (acc_cls == CLS_ROM);
  assign is_ram      = (acc_cls == CLS_RAM);
  assign is_bus      = !is_rom && !is_ram;
  assign rom_wr_drop = acc_valid && is_rom && !acc_rd;
  assign wt_wr       = acc_valid && is_ram && hit_wt && !acc_rd;

  assign shadow_wr = acc_valid && is_ram && !acc_rd;
  assign ext_req   = (acc_valid && is_bus) || wt_wr;
  assign ext_wr    = ext_req && !acc_rd;

  assign led_trig = {ext_req, acc_valid && is_ram, acc_valid && is_rom};

  mrd_led_stretch #(.NUM_CH(3), .STRETCH_W(STRETCH_W)) u_led (
    .clk(clk), .rst_n(rst_n), .trig(led_trig), .stretch(stretch), .led_n(led_vec)
  );

  assign led_rom_n = led_vec[0];
  assign led_ram_n = led_vec[1];
  assign led_bus_n = led_vec[2];
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter logic [15:0] ROM_FLOOR = 16'h4000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [15:0] acc_addr,
  input logic        acc_rd,
  input logic [1:0]  acc_cls,
  input logic [15:0] shadow_ofs,
  input logic        shadow_wr,
  input logic        ext_req,
  input logic        ext_wr,
  input logic        led_rom_n,
  input logic        led_bus_n,
  input logic        rom_wr_drop,
  input logic        wt_wr
);
  AST_EXT_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> (ext_req && !acc_rd)); // R1
  AST_UNMAPPED_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_cls == 2'd0) |-> ext_req); // R1
  AST_UNMAPPED_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cls == 2'd0) |-> (shadow_ofs == 16'h0)); // R3
  AST_ROM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cls == 2'd1) |-> (acc_addr >= ROM_FLOOR)); // R4
  AST_ROM_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr_drop |-> (!ext_req && !shadow_wr)); // R5
  AST_SHADOW_WR_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_wr |-> (acc_cls == 2'd2 && !acc_rd && acc_valid)); // R6
  AST_WT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    wt_wr |-> (shadow_wr && ext_wr)); // R7
  AST_LED_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_cls == 2'd1) |=> !led_rom_n); // R8
  AST_LED_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> !led_bus_n); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!ext_req && !shadow_wr)); // R11
endmodule

bind mem_region_decoder mrd_checker #(.ROM_FLOOR(ROM_FLOOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_rd(acc_rd), .acc_cls(acc_cls), .shadow_ofs(shadow_ofs),
  .shadow_wr(shadow_wr), .ext_req(ext_req), .ext_wr(ext_wr),
  .led_rom_n(led_rom_n), .led_bus_n(led_bus_n),
  .rom_wr_drop(rom_wr_drop), .wt_wr(wt_wr)
);

// File: tb/mem_region_decoder_tb.sv
`timescale 1ns/1ps
module mem_region_decoder_tb_top;
  localparam int NE = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic acc_rd = 1'b1;
  logic [1:0] acc_cls;
  logic [15:0] shadow_ofs;
  logic shadow_wr, ext_req, ext_wr, led_rom_n, led_ram_n, led_bus_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mem_region_decoder #(.NUM_ENTRIES(NE), .STRETCH_W(SW), .STRETCH_RST(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_cls(acc_cls), .shadow_ofs(shadow_ofs), .shadow_wr(shadow_wr),
    .ext_req(ext_req), .ext_wr(ext_wr), .led_rom_n(led_rom_n),
    .led_ram_n(led_ram_n), .led_bus_n(led_bus_n)
  );

  // Behavioural reference state
  int m_lo[NE], m_hi[NE], m_fold[NE], m_base[NE], m_cls[NE], m_wt[NE];
  int m_stretch = 4;
  int m_cnt[3] = '{0, 0, 0};

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, got, exp);
    end
  endtask

  function automatic void mdl_decode(input int a, output int c, output int o, output int w);
    c = 0; o = 0; w = 0;
    for (int i = 0; i < NE; i++) begin
      if ((m_cls[i] == 1 || m_cls[i] == 2) && a >= m_lo[i] && a <= m_hi[i] &&
          !(m_cls[i] == 1 && a < 'h4000)) begin
        c = m_cls[i];
        o = (m_base[i] + (((a - m_lo[i]) & 'hFFFF) & m_fold[i])) & 'hFFFF;
        w = m_wt[i];
        return;
      end
    end
  endfunction

  function automatic int exp_req();
    int c, o, w;
    mdl_decode(acc_addr, c, o, w);
    if (!acc_valid) return 0;
    return (c == 0 || (c == 2 && w == 1 && !acc_rd)) ? 1 : 0;
  endfunction

  // Reference update at each edge: indicators first, then configuration
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_fold[i] = 0; m_base[i] = 0; m_cls[i] = 0; m_wt[i] = 0;
      end
      m_stretch = 4;
      for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    end else begin
      int c, o, w, ld;
      bit tr[3];
      mdl_decode(acc_addr, c, o, w);
      tr[0] = acc_valid && c == 1;
      tr[1] = acc_valid && c == 2;
      tr[2] = exp_req() == 1;
      ld = (m_stretch == 0) ? 1 : m_stretch;
      for (int k = 0; k < 3; k++) begin
        if (tr[k]) m_cnt[k] = ld;
        else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_lo[cfg_idx] = cfg_data;
          3'd1: m_hi[cfg_idx] = cfg_data;
          3'd2: m_fold[cfg_idx] = cfg_data;
          3'd3: m_base[cfg_idx] = cfg_data;
          3'd4: begin m_cls[cfg_idx] = cfg_data[1:0]; m_wt[cfg_idx] = cfg_data[2]; end
          3'd7: m_stretch = cfg_data[SW-1:0];
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int c, o, w, rq;
      mdl_decode(acc_addr, c, o, w);
      rq = exp_req();
      chk("R2 class", acc_cls, c);
      chk("R3 offset", shadow_ofs, o);
      chk("R6 shadow_wr", shadow_wr, (acc_valid && c == 2 && !acc_rd) ? 1 : 0);
      chk("R1 ext_req", ext_req, rq);
      chk("R1 ext_wr", ext_wr, (rq == 1 && !acc_rd) ? 1 : 0);
      chk("R8 led_rom", led_rom_n, m_cnt[0] == 0 ? 1 : 0);
      chk("R8 led_ram", led_ram_n, m_cnt[1] == 0 ? 1 : 0);
      chk("R8 led_bus", led_bus_n, m_cnt[2] == 0 ? 1 : 0);
    end
  end

  task automatic cfg(input int idx, input int sel, input int data);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_sel = sel[2:0]; cfg_data = data[15:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic acc(input int a, input bit rd, input bit v = 1'b1);
    @(posedge clk); #1;
    acc_valid = v; acc_addr = a[15:0]; acc_rd = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; acc_valid = 1'b0;
    end
  endtask

  task automatic probe(input string tag, input int a, input bit rd, input int ec,
                       input int eo, input int esw, input int erq);
    acc(a, rd);
    @(negedge clk);
    chk({tag, " cls"}, acc_cls, ec);
    chk({tag, " ofs"}, shadow_ofs, eo);
    chk({tag, " swr"}, shadow_wr, esw);
    chk({tag, " req"}, ext_req, erq);
  endtask

  initial begin : watchdog
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #10 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 led_rom", led_rom_n, 1);
    chk("R9 led_ram", led_ram_n, 1);
    chk("R9 led_bus", led_bus_n, 1);
    probe("R9 unmapped", 'h0010, 1'b1, 0, 0, 0, 1);
    idle(6);

    // R10 program layout
    cfg(0, 0, 'h1000); cfg(0, 1, 'h10FF); cfg(0, 2, 'h00FF); cfg(0, 3, 'h0000); cfg(0, 4, 2);
    cfg(1, 0, 'h0000); cfg(1, 1, 'h13FF); cfg(1, 2, 'hFFFF); cfg(1, 3, 'h0000); cfg(1, 4, 2);
    cfg(2, 0, 'h3000); cfg(2, 1, 'hFFFF); cfg(2, 2, 'hFFFF); cfg(2, 3, 'h0000); cfg(2, 4, 1);
    cfg(3, 0, 'h2000); cfg(3, 1, 'h20FF); cfg(3, 2, 'h00FF); cfg(3, 3, 'h1400); cfg(3, 4, 6);

    probe("R2 R3 mirror", 'h1005, 1'b1, 2, 'h0005, 0, 0);
    probe("R2 low ram", 'h0FFF, 1'b1, 2, 'h0FFF, 0, 0);
    probe("R3 above mirror", 'h1200, 1'b1, 2, 'h1200, 0, 0);
    probe("R2 ram top", 'h13FF, 1'b1, 2, 'h13FF, 0, 0);
    probe("R1 past ram", 'h1400, 1'b0, 0, 0, 0, 1);
    chk("R1 ext_wr", ext_wr, 1);
    probe("R4 below floor", 'h3FFF, 1'b1, 0, 0, 0, 1);
    probe("R4 at floor", 'h4000, 1'b1, 1, 'h1000, 0, 0);
    probe("R5 rom write", 'h8000, 1'b0, 1, 'h5000, 0, 0);
    probe("R6 ram write", 'h0010, 1'b0, 2, 'h0010, 1, 0);
    probe("R7 wt write", 'h2042, 1'b0, 2, 'h1442, 1, 1);
    chk("R7 ext_wr", ext_wr, 1);
    probe("R7 wt read", 'h2042, 1'b1, 2, 'h1442, 0, 0);

    // R11 no valid access
    acc('h1400, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 req", ext_req, 0);
    chk("R11 swr", shadow_wr, 0);
    idle(8);
    chk("R11 led_bus", led_bus_n, 1);

    // R8 stretch of 2, then 0 (treated as 1), then 7
    cfg(0, 7, 2);
    acc('h4000, 1'b1);
    idle(1);
    @(negedge clk); chk("R8 first", led_rom_n, 0);
    idle(1); @(negedge clk); chk("R8 second", led_rom_n, 0);
    idle(1); @(negedge clk); chk("R8 off", led_rom_n, 1);
    cfg(2, 7, 0);
    acc('h0020, 1'b1);
    idle(1); @(negedge clk); chk("R8 zero on", led_ram_n, 0);
    idle(1); @(negedge clk); chk("R8 zero off", led_ram_n, 1);
    cfg(1, 7, 7);
    acc('h5555, 1'b1); acc('h5555, 1'b1); idle(3);
    acc('h7000, 1'b1);
    idle(10);

    // R10 ignored selects and disabling an entry
    cfg(0, 5, 'h0000); cfg(0, 6, 'hFFFF);
    probe("R10 sel ignored", 'h1005, 1'b1, 2, 'h0005, 0, 0);
    cfg(3, 4, 0);
    probe("R10 disabled", 'h2042, 1'b0, 0, 0, 0, 1);
    cfg(1, 4, 1);
    probe("R4 rom low range", 'h0010, 1'b1, 0, 0, 0, 1);
    idle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule